// File: doc/BRIEF.md
# Streaming Histogram Binning Engine

This block builds a histogram over a stream of samples and then streams the finished bin counts out. A one-cycle start pulse carries the number of samples to process. The block first sweeps its on-chip count memory to zero, then accepts exactly that many samples on a valid/ready input stream. Each sample picks a bin from a slice of its low bits, and that bin's counter goes up by one. Binning is pipelined, so a new sample can be taken every cycle while earlier ones are still being written back.

Once the last sample has been counted, the block sends every bin count on a valid/ready output stream, lowest bin first. It then pulses a done flag and returns to idle, ready for the next start. By default it has 512 bins of 32-bit counts. The bin number is bits 15:7 of each sample.

Top module: `hist_bin_engine`

## Requirements
- R1: While reset is active and in the first cycle after it, `in_ready`, `out_valid` and `done` are all low.
- R2: After a start pulse, the block accepts exactly `start_len` samples. `in_ready` is then deasserted, and it stays low until the following start.
- R3: A sample's bin is bits [KEEP_W-1 : KEEP_W-BIN_BITS] of the sample (bits 15:7 by default). All other sample bits have no effect on the result.
- R4: Each accepted sample adds exactly one to its bin. This holds when samples for the same bin arrive on consecutive cycles, and when two bins alternate.
- R5: Every bin is cleared at the start of each run, so counts never carry over from an earlier run. `in_ready` stays low while clearing is in progress.
- R6: The output phase begins only after all samples are consumed. It sends exactly 2^BIN_BITS words, bin 0 first and ascending, and `in_ready` is never high while `out_valid` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value.
- R8: `done` is high for exactly one cycle, in the cycle after the last output word is accepted. `out_valid` is low from that cycle on.
- R9: A `start_len` of zero skips accumulation. The block still outputs every bin, each with the value zero.
- R10: Bin counters wrap modulo 2^CNT_W.
- R11: A start pulse arriving while a run is in progress is ignored. The run keeps its original length and counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a run (taken only when idle) |
| start_len | input | LEN_W | Number of samples in the run, sampled with `start` |
| in_valid | input | 1 | Sample present on `in_data` |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | SAMPLE_W | Sample word |
| out_valid | output | 1 | Bin count present on `out_data` |
| out_ready | input | 1 | Downstream accepts the bin count |
| out_data | output | CNT_W | Bin count, ascending bin order |
| done | output | 1 | One-cycle pulse after the final bin word is accepted |

## Verification
The bench builds the engine with KEEP_W=8, BIN_BITS=4 and CNT_W=8, so there are 16 bins indexed by sample bits 7:4. With only 16 bins, every bin's output word is checked on each run, and the clearing sweep takes 16 cycles. With 8-bit counters, the wrap case takes only 257 samples into one bin. Sample words carry nonzero upper bytes and low nibbles, so bits that must not affect the bin are exercised. Back-to-back and alternating same-bin sequences exercise the write-back forwarding path.

// File: rtl/hist_bin_engine.sv
module hist_bin_engine #(
  parameter int SAMPLE_W = 32,
  parameter int KEEP_W   = 16,
  parameter int BIN_BITS = 9,
  parameter int CNT_W    = 32,
  parameter int LEN_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LEN_W-1:0]    start_len,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_data,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [CNT_W-1:0]    out_data,
  output logic                done
);
  localparam int NBINS = 1 << BIN_BITS;
  localparam int LO    = KEEP_W - BIN_BITS;
  localparam int PTR_W = BIN_BITS + 1;

  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_ACC, S_DRAIN, S_DUMP} st_t;

  st_t                  st;
  logic [LEN_W-1:0]     rem;
  logic [BIN_BITS-1:0]  clr_idx;
  logic [CNT_W-1:0]     mem [NBINS];

  logic                 p_vld, w_vld;
  logic [BIN_BITS-1:0]  p_idx, w_idx;
  logic [CNT_W-1:0]     p_rd, w_val;
  logic [PTR_W-1:0]     fetch;

  logic                 unused_bits;
  assign unused_bits = ^{in_data[SAMPLE_W-1:KEEP_W], in_data[LO-1:0]};

  wire [BIN_BITS-1:0] in_idx = in_data[KEEP_W-1:LO];
  assign in_ready = (st == S_ACC);
  wire take = in_valid && in_ready;

  // newest pending write wins over the stale memory read
  wire [CNT_W-1:0] p_sum = ((w_vld && w_idx == p_idx) ? w_val : p_rd) + CNT_W'(1);

  wire pop  = out_valid && out_ready;
  wire more = (fetch != PTR_W'(NBINS));
  wire load = (st == S_DUMP) && more && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (st == S_CLEAR)
      mem[clr_idx] <= '0;
    else if (p_vld)
      mem[p_idx] <= p_sum;
    p_rd <= mem[in_idx];
    if (load)
      out_data <= mem[fetch[BIN_BITS-1:0]];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      rem       <= '0;
      clr_idx   <= '0;
      p_vld     <= 1'b0;
      p_idx     <= '0;
      w_vld     <= 1'b0;
      w_idx     <= '0;
      w_val     <= '0;
      fetch     <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
    end else begin
      done  <= 1'b0;
      p_vld <= take;
      if (take) p_idx <= in_idx;
      w_vld <= p_vld;
      w_idx <= p_idx;
      w_val <= p_sum;
      case (st)
        S_IDLE: if (start) begin
          rem     <= start_len;
          clr_idx <= '0;
          st      <= S_CLEAR;
        end
        S_CLEAR: begin
          clr_idx <= clr_idx + BIN_BITS'(1);
          if (clr_idx == BIN_BITS'(NBINS - 1))
            st <= (rem == '0) ? S_DRAIN : S_ACC;
        end
        S_ACC: if (take) begin
          rem <= rem - LEN_W'(1);
          if (rem == LEN_W'(1)) st <= S_DRAIN;
        end
        S_DRAIN: begin
          fetch <= '0;
          st    <= S_DUMP;
        end
        S_DUMP: begin
          if (load) begin
            out_valid <= 1'b1;
            fetch     <= fetch + PTR_W'(1);
          end else if (pop) begin
            out_valid <= 1'b0;
          end
          if (pop && !more) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !out_valid);

  assert_done_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready));

  assert_phase_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  assert_rem_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rem == $past(rem) - LEN_W'(1));

endmodule

// File: tb/hist_bin_engine_tb.sv
module hist_bin_engine_tb_top;
  localparam int SW = 32, KW = 8, BB = 4, CW = 8, LW = 16;
  localparam int NB = 1 << BB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [LW-1:0] start_len = '0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [SW-1:0] in_data = '0;
  logic in_ready, out_valid, done;
  logic [CW-1:0] out_data;

  always #10 clk = ~clk;

  hist_bin_engine #(.SAMPLE_W(SW), .KEEP_W(KW), .BIN_BITS(BB), .CNT_W(CW), .LEN_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_len(start_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .done(done));

  localparam logic [31:0] VEC [0:19] = '{
    32'hDEAD_0035, 32'h0000_003F, 32'hFFFF_FF30, 32'h1234_5601, 32'h0000_00F0,
    32'h8000_00FF, 32'h0000_0050, 32'h0000_0060, 32'h0000_0055, 32'h0000_0061,
    32'hABCD_EF7E, 32'h0000_0070, 32'h0000_0071, 32'h0000_0072, 32'h0000_0100,
    32'h0000_0A80, 32'h0000_0B90, 32'h0000_00A0, 32'h0000_00C5, 32'h0000_00E9};

  int total = 0, bad = 0;
  logic [31:0] stim [0:299];
  logic [CW-1:0] expv [0:NB-1];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_run(input int n, input bit gaps, input bit stalls, input bit late_start);
    for (int b = 0; b < NB; b++) expv[b] = '0;
    for (int i = 0; i < n; i++) expv[stim[i][KW-1:KW-BB]] += CW'(1);
    @(negedge clk);
    start = 1'b1; start_len = LW'(n);
    @(negedge clk);
    start = 1'b0;
    chk(!in_ready, "R5 not ready while clearing", 32'(in_ready), 0);
    for (int i = 0; i < n; i++) begin
      if (gaps && (i % 4 == 2)) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_data = stim[i];
      while (!in_ready) @(negedge clk);
      if (late_start && i == 1) begin start = 1'b1; start_len = LW'(3); end
      @(negedge clk);
      start = 1'b0;
    end
    in_valid = 1'b0;
    chk(!in_ready, "R2 ready drops after last sample", 32'(in_ready), 0);
    for (int i = 0; i < NB; i++) begin
      out_ready = !(stalls && (i % 3 == 1));
      while (!out_valid) @(negedge clk);
      if (!out_ready) begin
        automatic logic [CW-1:0] held = out_data;
        @(negedge clk);
        chk(out_valid && out_data == held, "R7 stable under stall", 32'(out_data), 32'(held));
        out_ready = 1'b1;
      end
      chk(out_data == expv[i], $sformatf("R6/R4 bin %0d", i), 32'(out_data), 32'(expv[i]));
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(done && !out_valid, "R8 done after last word", {30'd0, done, out_valid}, 32'h2);
    @(negedge clk);
    chk(!done && !out_valid, "R8 done one cycle", {30'd0, done, out_valid}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!in_ready && !out_valid && !done, "R1 reset outputs", {29'd0, in_ready, out_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!in_ready && !out_valid && !done, "R1 after release", {29'd0, in_ready, out_valid, done}, 0);

    // R3 R4 table walk: mixed upper bits, same-bin bursts, alternating bins
    foreach (VEC[k]) stim[k] = VEC[k];
    do_run(20, 1'b0, 1'b0, 1'b0);
    do_run(20, 1'b1, 1'b1, 1'b0);

    // R5: fresh run must not include earlier counts
    for (int i = 0; i < 5; i++) stim[i] = 32'h0000_0090 + 32'(i);
    do_run(5, 1'b0, 1'b1, 1'b0);

    // R9: zero length
    do_run(0, 1'b0, 1'b1, 1'b0);

    // R10: 257 hits on bin 3 wraps to 1
    for (int i = 0; i < 257; i++) stim[i] = 32'hFF00_1234;
    do_run(257, 1'b0, 1'b0, 1'b0);

    // R11: start during a run is ignored
    for (int i = 0; i < 6; i++) stim[i] = 32'(i) << 4;
    do_run(6, 1'b1, 1'b0, 1'b1);

    // R1: reset in the middle of the output phase
    @(negedge clk);
    start = 1'b1; start_len = '0;
    @(negedge clk);
    start = 1'b0;
    while (!out_valid) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!out_valid && !in_ready && !done, "R1 mid-run reset", {29'd0, in_ready, out_valid, done}, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) stim[i] = 32'h0000_00F7;
    do_run(3, 1'b0, 1'b0, 1'b0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule